// File: doc/BRIEF.md
# Flow-Through Synchronous Burst RAM

This block is a cycle model of a single-port synchronous memory with byte lanes, meant to stand in for a burst cache RAM in a processor-side memory subsystem. Address, control and write data are captured on the rising clock edge. Read data is not registered: it is driven from the array at the captured address during the cycle that follows the capturing edge. A separate read bus, write bus and valid flag take the place of a bidirectional data bus. When the valid flag is low, the read bus is zero. This models the high-impedance state.

An access is started by one of two address strobes. The processor strobe only counts when chip enable is low, and it suppresses any write in its own cycle. The controller strobe is not gated by chip enable and permits a write in the same cycle. Once an access is open, the advance input steps a two-bit burst offset through four words. The step order is either interleaved or linear and wraps back to the first word. When advance is inactive, the burst is suspended on the current word. The block has a global write input, a byte-write path with one select per lane, an asynchronous output enable and a sleep input. Sleep freezes the block and leaves it deselected afterwards.

Top module: `fts_burst_ram`

## Requirements
- R1: A starting edge selects the device only when ce_n=0, cs0=1 and cs1_n=0. Any other combination on a starting edge is a deselect: rvalid is 0 in the following cycles until a selecting start occurs.
- R2: After a controller start (strb_ctrl_n=0) that does not write, the next cycle shows rvalid=1 and rdata equal to the word at addr, provided out_en_n=0.
- R3: wr_all_n=0 on an access edge writes all four byte lanes from wdata, regardless of lane_wr_en_n and lane_sel_n.
- R4: With wr_all_n=1 and lane_wr_en_n=0, each lane_sel_n bit i that is 0 writes bits 8i+7..8i only. Bit 0 covers bits 7..0, and any set of lanes may be written in one edge.
- R5: wr_all_n=1 together with lane_wr_en_n=1 writes nothing.
- R6: An edge with strb_proc_n=0 and ce_n=0 writes nothing, whatever the write inputs are. A write on the following continuing edge takes effect at the captured address.
- R7: strb_proc_n=0 while ce_n=1 starts nothing. An open burst continues on its current word.
- R8: With mode_ilv=1 captured at the start, the k-th advance reads word offset (base XOR k) mod 4 within the aligned four-word block.
- R9: With mode_ilv=0, the k-th advance reads offset (base + k) mod 4. After four advances the burst returns to the starting word in both modes.
- R10: A continuing edge with step_n=1 keeps the same word.
- R11: out_en_n=1 forces rvalid=0 combinationally within the same cycle, without waiting for a clock edge.
- R12: In the cycle after any edge that writes, rvalid=0.
- R13: While sleep=1, rvalid=0, no write occurs and the array keeps its contents. After sleep ends, the device is deselected until a new selecting start.
- R14: After reset, rvalid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the access state |
| ce_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| cs0 | input | 1 | Chip select, active high |
| cs1_n | input | 1 | Chip select, active low |
| strb_proc_n | input | 1 | Processor address strobe, active low; blocks writes in its cycle |
| strb_ctrl_n | input | 1 | Controller address strobe, active low; not gated by ce_n |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enables the per-lane selects, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low, bit i is byte i |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Freezes the block while high |
| mode_ilv | input | 1 | Burst order captured at start: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address captured on a start |
| wdata | input | 8*LANES | Write data |
| rdata | output | 8*LANES | Flow-through read data, zero when rvalid is low |
| rvalid | output | 1 | Read data is being driven |

## Verification
The assertions take for granted that the strobes, selects and write controls are stable around the rising edge. They also assume mode_ilv changes only between bursts, and that sleep is not raised or dropped in the middle of a write that the checks depend on. The stimulus changes every input one time unit after a rising edge and samples outputs at that same moment. The only exception is out_en_n, which is toggled between edges to exercise its asynchronous path. Each burst is preceded by single writes that fill its whole four-word block, so every word a burst visits holds a known value.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int unsigned BURST_LEN = 4;
  typedef logic [1:0] boff_t;

  // word offset inside a four-word block for the given advance count
  function automatic boff_t burst_off(boff_t base, boff_t cnt, logic ilv);
    boff_t r;
    if (ilv) r = base ^ cnt;
    else     r = boff_t'(base + cnt);
    return r;
  endfunction
endpackage

// File: rtl/fts_cmd_decode.sv
module fts_cmd_decode #(
  parameter int unsigned LANES = 4
) (
  input  logic             ce_n,
  input  logic             cs0,
  input  logic             cs1_n,
  input  logic             strb_proc_n,
  input  logic             strb_ctrl_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             sleep,
  input  logic             act_q,
  output logic             load,
  output logic             adv,
  output logic             sel_now,
  output logic             act_d,
  output logic [LANES-1:0] lane_we
);
  logic             proc_start;
  logic             ctrl_start;
  logic             wr_ok;
  logic [LANES-1:0] lane_req;

  assign proc_start = !strb_proc_n && !ce_n;
  assign ctrl_start = !strb_ctrl_n;
  assign sel_now    = !ce_n && cs0 && !cs1_n;
  assign load       = !sleep && (proc_start || ctrl_start);
  assign adv        = !sleep && !load && act_q && !step_n;

  always_comb begin
    if (sleep)     act_d = 1'b0;
    else if (load) act_d = sel_now;
    else           act_d = act_q;
  end

  always_comb begin
    if (!wr_all_n)          lane_req = '1;
    else if (!lane_wr_en_n) lane_req = ~lane_sel_n;
    else                    lane_req = '0;
  end

  assign wr_ok   = !sleep && !proc_start && (load ? sel_now : act_q);
  assign lane_we = wr_ok ? lane_req : '0;
endmodule

// File: rtl/fts_burst_ctr.sv
module fts_burst_ctr
  import fts_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int unsigned HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q, hi_n;
  boff_t           base_q, base_n, cnt_q, cnt_n;
  logic            ilv_q, ilv_n;

  always_comb begin
    hi_n   = hi_q;
    base_n = base_q;
    cnt_n  = cnt_q;
    ilv_n  = ilv_q;
    if (load) begin
      hi_n   = addr_in[ADDR_W-1:2];
      base_n = addr_in[1:0];
      cnt_n  = '0;
      ilv_n  = mode_ilv;
    end else if (adv) begin
      cnt_n  = boff_t'(cnt_q + 2'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else begin
      hi_q   <= hi_n;
      base_q <= base_n;
      cnt_q  <= cnt_n;
      ilv_q  <= ilv_n;
    end
  end

  assign wr_addr = {hi_n, burst_off(base_n, cnt_n, ilv_n)};
  assign rd_addr = {hi_q, burst_off(base_q, cnt_q, ilv_q)};
endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANES  = 4
) (
  input  logic               clk,
  input  logic [LANES-1:0]   we,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [8*LANES-1:0] wdata,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [8*LANES-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) cells[waddr] <= wdata[8*g +: 8];
    end
    assign rdata[8*g +: 8] = cells[raddr];
  end
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DATA_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              cs0,
  input  logic              cs1_n,
  input  logic              strb_proc_n,
  input  logic              strb_ctrl_n,
  input  logic              step_n,
  input  logic              wr_all_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              out_en_n,
  input  logic              sleep,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              load, adv, sel_now, act_d, act_q, wr_q;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] arr_rd;

  fts_cmd_decode #(.LANES(LANES)) u_dec (
    .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .sleep(sleep), .act_q(act_q),
    .load(load), .adv(adv), .sel_now(sel_now), .act_d(act_d), .lane_we(lane_we)
  );

  fts_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .mode_ilv(mode_ilv),
    .addr_in(addr), .wr_addr(wr_addr), .rd_addr(rd_addr)
  );

  fts_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
    .clk(clk), .we(lane_we), .waddr(wr_addr), .wdata(wdata),
    .raddr(rd_addr), .rdata(arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      wr_q  <= |lane_we;
    end
  end

  assign rvalid = act_q && !wr_q && !out_en_n && !sleep;
  assign rdata  = rvalid ? arr_rd : '0;
endmodule

// File: rtl/fts_burst_ram_chk.sv
module fts_burst_ram_chk #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              cs0,
  input logic              cs1_n,
  input logic              strb_proc_n,
  input logic              strb_ctrl_n,
  input logic              step_n,
  input logic              out_en_n,
  input logic              sleep,
  input logic [ADDR_W-1:0] addr,
  input logic              rvalid,
  input logic              act_q,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [LANES-1:0]  arr_we
);
  logic starting, continuing, selecting;
  assign starting   = !strb_ctrl_n || (!strb_proc_n && !ce_n);
  assign continuing = !starting;
  assign selecting  = !ce_n && cs0 && !cs1_n;

  // R1
  desel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && starting && !selecting) |=> !rvalid);
  // R2
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !strb_ctrl_n) |=> (rd_addr == $past(addr)));
  // R6
  proc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_proc_n && !ce_n) |-> (arr_we == '0));
  // R9
  advance_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && act_q && continuing && !step_n) |=> (rd_addr[1:0] != $past(rd_addr[1:0])));
  // R10
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && continuing && step_n) |=> $stable(rd_addr));
  // R11
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rvalid);
  // R12
  write_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|arr_we) |=> !rvalid);
  // R13
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rvalid && arr_we == '0));
endmodule

bind fts_burst_ram fts_burst_ram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n),
  .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .step_n(step_n),
  .out_en_n(out_en_n), .sleep(sleep), .addr(addr), .rvalid(rvalid),
  .act_q(act_q), .rd_addr(rd_addr), .arr_we(lane_we)
);

// File: tb/fts_burst_ram_bench.sv
module fts_burst_ram_bench;
  localparam int unsigned PERIOD = 10;
  localparam int unsigned AW     = 9;
  localparam int unsigned DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n, cs0, cs1_n, strb_proc_n, strb_ctrl_n, step_n;
  logic          wr_all_n, lane_wr_en_n, out_en_n, sleep, mode_ilv;
  logic [3:0]    lane_sel_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic          rvalid;

  logic [31:0]   sb [DEPTH];
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  fts_burst_ram u_fts_burst_ram (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .sleep(sleep), .mode_ilv(mode_ilv),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ce_n = 0; cs0 = 1; cs1_n = 0;
    strb_proc_n = 1; strb_ctrl_n = 1; step_n = 1;
    wr_all_n = 1; lane_wr_en_n = 1; lane_sel_n = 4'hF;
    out_en_n = 0; sleep = 0;
  endtask

  // controller-started write; lanes follow the write rules in the brief
  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic g_n, logic be_n,
                    logic [3:0] s_n, string tag);
    logic [3:0] lanes;
    lanes = !g_n ? 4'hF : (!be_n ? ~s_n : 4'h0);
    strb_ctrl_n = 0; addr = a; wdata = d;
    wr_all_n = g_n; lane_wr_en_n = be_n; lane_sel_n = s_n;
    tick();
    for (int i = 0; i < 4; i++)
      if (lanes[i]) sb[a][8*i +: 8] = d[8*i +: 8];
    if (lanes != 0) chk({tag, " R12 rvalid after write"}, {31'd0, rvalid}, 32'd0);
    idle();
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    strb_ctrl_n = 0; addr = a;
    tick();
    chk({tag, " rvalid"}, {31'd0, rvalid}, 32'd1);
    chk({tag, " rdata"}, rdata, sb[a]);
    idle();
  endtask

  task automatic t_reset();
    chk("R14 rvalid after reset", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_global();
    wr(9'h010, 32'h1111_1111, 1, 1, 4'hF, "R3 seed");
    wr(9'h010, 32'hA5C3_0F96, 0, 0, 4'b1110, "R3");
    chk("R3 all lanes model", sb[9'h010], 32'hA5C3_0F96);
    rd(9'h010, "R3 R2 readback");
  endtask

  task automatic t_lanes();
    wr(9'h011, 32'h0000_0000, 0, 1, 4'hF, "R4 seed");
    wr(9'h011, 32'hDEAD_BEEF, 1, 0, 4'b1010, "R4");
    chk("R4 lanes 0 and 2 model", sb[9'h011], 32'h00AD_00EF);
    rd(9'h011, "R4 readback");
    wr(9'h011, 32'h1234_5678, 1, 0, 4'b0111, "R4 top");
    rd(9'h011, "R4 lane 3 readback");
    // R5: both write controls high on a start: read of the old word
    strb_ctrl_n = 0; addr = 9'h011; wdata = 32'hFFFF_FFFF; lane_sel_n = 4'h0;
    tick();
    chk("R5 no write rvalid", {31'd0, rvalid}, 32'd1);
    chk("R5 no write rdata", rdata, 32'h12AD_00EF);
    idle();
  endtask

  task automatic t_proc_block();
    wr(9'h020, 32'hCAFE_0001, 0, 1, 4'hF, "R6 seed");
    strb_proc_n = 0; addr = 9'h020; wdata = 32'hBAD0_BAD0; wr_all_n = 0;
    tick();
    chk("R6 blocked write shows read", {31'd0, rvalid}, 32'd1);
    chk("R6 blocked write rdata", rdata, 32'hCAFE_0001);
    strb_proc_n = 1; wdata = 32'h600D_F00D; wr_all_n = 0;
    tick();
    chk("R6 R12 follow-on write rvalid", {31'd0, rvalid}, 32'd0);
    idle();
    sb[9'h020] = 32'h600D_F00D;
    rd(9'h020, "R6 follow-on write readback");
  endtask

  task automatic t_proc_gated();
    wr(9'h030, 32'h0303_0303, 0, 1, 4'hF, "R7 seed");
    wr(9'h031, 32'h3131_3131, 0, 1, 4'hF, "R7 seed2");
    rd(9'h030, "R7 open");
    ce_n = 1; strb_proc_n = 0; addr = 9'h031;
    tick();
    chk("R7 gated strobe rvalid", {31'd0, rvalid}, 32'd1);
    chk("R7 gated strobe rdata", rdata, 32'h0303_0303);
    idle();
  endtask

  task automatic t_select();
    rd(9'h010, "R1 open");
    for (int k = 0; k < 3; k++) begin
      strb_ctrl_n = 0; addr = 9'h010;
      ce_n = (k == 0); cs0 = (k != 1); cs1_n = (k == 2);
      tick();
      chk($sformatf("R1 deselect case %0d", k), {31'd0, rvalid}, 32'd0);
      idle();
      tick();
      chk($sformatf("R1 stays deselected %0d", k), {31'd0, rvalid}, 32'd0);
      rd(9'h010, "R1 reselect");
    end
    strb_proc_n = 0; cs0 = 0; addr = 9'h010;
    tick();
    chk("R1 processor start deselect", {31'd0, rvalid}, 32'd0);
    idle();
  endtask

  task automatic t_burst(logic [AW-1:0] start, logic ilv);
    logic [AW-1:0] blk;
    logic [1:0]    off;
    string         tag;
    tag = ilv ? "R8" : "R9";
    blk = {start[AW-1:2], 2'b00};
    for (int j = 0; j < 4; j++)
      wr(blk + AW'(j), {8'hB0 + 8'(j), 15'd0, start}, 0, 1, 4'hF, {tag, " fill"});
    mode_ilv = ilv;
    rd(start, {tag, " first word"});
    for (int k = 1; k <= 4; k++) begin
      off = ilv ? (start[1:0] ^ 2'(k)) : 2'(start[1:0] + 2'(k));
      step_n = 0;
      tick();
      chk($sformatf("%s advance %0d", tag, k), rdata, sb[{start[AW-1:2], off}]);
      if (k == 1) begin
        step_n = 1;
        tick();
        chk($sformatf("R10 suspend in %s", tag), rdata, sb[{start[AW-1:2], off}]);
      end
    end
    idle();
  endtask

  task automatic t_oe();
    rd(9'h010, "R11 open");
    out_en_n = 1;
    #1;
    chk("R11 async off", {31'd0, rvalid}, 32'd0);
    out_en_n = 0;
    #1;
    chk("R11 async on", {31'd0, rvalid}, 32'd1);
  endtask

  task automatic t_sleep();
    rd(9'h020, "R13 open");
    sleep = 1;
    #1;
    chk("R13 sleep output off", {31'd0, rvalid}, 32'd0);
    strb_ctrl_n = 0; addr = 9'h020; wdata = 32'h5EE9_5EE9; wr_all_n = 0;
    tick();
    chk("R13 sleeping", {31'd0, rvalid}, 32'd0);
    idle();
    tick();
    chk("R13 deselected after wake", {31'd0, rvalid}, 32'd0);
    rd(9'h020, "R13 retained");
  endtask

  initial begin
    idle();
    mode_ilv = 1; addr = '0; wdata = '0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_global();
    t_lanes();
    t_proc_block();
    t_proc_gated();
    t_select();
    t_burst(9'h041, 1'b1);
    t_burst(9'h086, 1'b0);
    t_burst(9'h0C7, 1'b1);
    t_burst(9'h0E3, 1'b0);
    t_oe();
    t_sleep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule